// File: doc/BRIEF.md
# Asynchronous SRAM Write-Cycle Sequencer

This block turns a single-beat host write request into a write cycle on an asynchronous static RAM port. The RAM port has active-low strobes for the memory array enable, the semaphore enable, read/write and output enable. The sequencer keeps the order of those strobes correct. It drives the address and data in step with them. It times every interval (address setup, address-valid-to-end, write pulse, data setup, output turn-off, data hold, recovery) as a programmable number of clock cycles.

Two cycle styles can be selected. In the write-strobe style the target enable falls first and read/write sets the pulse. In the enable style read/write is already low and the target enable sets the pulse. The host can ask the block to keep output enable low during the cycle. In the write-strobe style the block then lengthens the pulse and delays its data drive, so the RAM's own output drivers are off before data is driven. The host hands over a request with a valid/ready handshake. A one-clock done pulse marks the end of recovery.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset memCeN, memSemN, memRwN and memOeN are 1, memDoe and done are 0, and reqReady is 1.
- R2: A request with reqSem=0 targets the array: memCeN goes low and memSemN stays 1. With reqSem=1, memSemN goes low and memCeN stays 1. The two are never low in the same cycle.
- R3: Address and data are captured on the clock edge where reqValid and reqReady are both 1. memAddr changes only while memCeN, memSemN and memRwN are all 1.
- R4: With cfgCeMode=0 (write-strobe style), the target enable falls on the first cycle after acceptance. memRwN falls S cycles later, where S = max(1, cfgSetupCnt). memRwN stays low for P cycles and then rises in the same cycle as the enable.
- R5: With cfgCeMode=1 (enable style), memRwN falls on the first cycle after acceptance. The target enable falls S cycles later and stays low for P cycles. Both then rise together.
- R6: P = max(1, cfgPulseCnt, cfgDataSetupCnt, cfgAddrValidCnt − cfgSetupCnt when positive, and cfgTurnoffCnt + cfgDataSetupCnt when cfgCeMode=0 and cfgOeLow=1).
- R7: When cfgOeLow=1 at acceptance, memOeN is 0 from the first strobe change until the end of recovery. Otherwise memOeN stays 1.
- R8: Data drive (memDoe=1) starts on the first cycle after acceptance. The one exception is cfgCeMode=0 with cfgOeLow=1: there it starts cfgTurnoffCnt cycles after memRwN falls. memDout equals the captured data whenever memDoe is 1.
- R9: memDoe stays 1 for cfgHoldCnt cycles after the strobes rise and then turns off.
- R10: After the strobes rise they stay high for Q = max(1, cfgRecovCnt, cfgHoldCnt) cycles before the next address change. done is 1 for exactly the last of those cycles.
- R11: reqReady is 0 from the accepting edge until the cycle in which done is 1. A request presented while reqReady is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Host write request |
| reqReady | output | 1 | Sequencer idle, request will be taken |
| reqAddr | input | AW | Write address |
| reqData | input | DW | Write data |
| reqSem | input | 1 | Target select: 0 array, 1 semaphore |
| cfgCeMode | input | 1 | 0 write-strobe style, 1 enable style |
| cfgOeLow | input | 1 | Keep output enable low during the cycle |
| cfgSetupCnt | input | CW | Address setup cycles |
| cfgPulseCnt | input | CW | Minimum write pulse cycles |
| cfgAddrValidCnt | input | CW | Address valid to end of write cycles |
| cfgDataSetupCnt | input | CW | Data valid before strobe rise cycles |
| cfgTurnoffCnt | input | CW | RAM output turn-off cycles |
| cfgHoldCnt | input | CW | Data hold cycles after strobe rise |
| cfgRecovCnt | input | CW | Write recovery cycles |
| memAddr | output | AW | RAM address |
| memDout | output | DW | RAM write data |
| memDoe | output | 1 | Data drive enable |
| memCeN | output | 1 | Array enable, active low |
| memSemN | output | 1 | Semaphore enable, active low |
| memRwN | output | 1 | Read/write, low for write |
| memOeN | output | 1 | Output enable, active low |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
A phase counter that stops or moves one cycle too early shows up at the ports in the very next cycle. Either a strobe edge moves relative to the others, or memDoe turns on or off at the wrong cycle. A wrongly latched target or style bit shows up on the first cycle after acceptance as the wrong enable or the wrong strobe order. Any slip in recovery moves done and reqReady, and with them the next address change. For this reason every port is compared in every cycle of each transaction, against a waveform derived from S, P and Q.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  // phase of the write sequence
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_RECOV
  } seqState_t;

  // control -> datapath strobe bundle (load is used unregistered)
  typedef struct packed {
    logic load;
    logic ceN;
    logic semN;
    logic rwN;
    logic oeN;
    logic drive;
    logic done;
  } strobeSet_t;

endpackage

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
  import sram_wr_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqSem,
  input  logic          cfgCeMode,
  input  logic          cfgOeLow,
  input  logic [CW-1:0] cfgSetupCnt,
  input  logic [CW-1:0] cfgPulseCnt,
  input  logic [CW-1:0] cfgAddrValidCnt,
  input  logic [CW-1:0] cfgDataSetupCnt,
  input  logic [CW-1:0] cfgTurnoffCnt,
  input  logic [CW-1:0] cfgHoldCnt,
  input  logic [CW-1:0] cfgRecovCnt,
  output logic          reqReady,
  output strobeSet_t    strobes
);

  localparam int KW = CW + 1;
  localparam logic [KW-1:0] ONE = KW'(1);

  seqState_t     state;
  logic [KW-1:0] cnt;
  logic [KW-1:0] aux;
  logic          semR;
  logic          ceModeR;
  logic          oeLowR;
  logic          accept;
  logic          lateDrive;
  logic [KW-1:0] setupLen;
  logic [KW-1:0] pulseLen;
  logic [KW-1:0] recovLen;

  function automatic logic [KW-1:0] maxOf(input logic [KW-1:0] a, input logic [KW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  assign accept    = reqValid && (state == ST_IDLE);
  assign reqReady  = (state == ST_IDLE);
  assign lateDrive = !ceModeR && oeLowR;

  always_comb begin
    logic [KW-1:0] awRest;
    logic [KW-1:0] turnSum;
    awRest  = (cfgAddrValidCnt > cfgSetupCnt) ? KW'(cfgAddrValidCnt - cfgSetupCnt) : '0;
    turnSum = lateDrive ? (KW'(cfgTurnoffCnt) + KW'(cfgDataSetupCnt)) : '0;
    setupLen = maxOf(KW'(cfgSetupCnt), ONE);
    pulseLen = maxOf(maxOf(KW'(cfgPulseCnt), KW'(cfgDataSetupCnt)),
                     maxOf(maxOf(awRest, turnSum), ONE));
    recovLen = maxOf(maxOf(KW'(cfgRecovCnt), KW'(cfgHoldCnt)), ONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      aux     <= '0;
      semR    <= 1'b0;
      ceModeR <= 1'b0;
      oeLowR  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            semR    <= reqSem;
            ceModeR <= cfgCeMode;
            oeLowR  <= cfgOeLow;
            cnt     <= setupLen;
            state   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt <= ONE) begin
            state <= ST_PULSE;
            cnt   <= pulseLen;
            aux   <= KW'(cfgTurnoffCnt);
          end else begin
            cnt <= cnt - ONE;
          end
        end
        ST_PULSE: begin
          if (aux != '0) aux <= aux - ONE;
          if (cnt <= ONE) begin
            state <= ST_RECOV;
            cnt   <= recovLen;
            aux   <= KW'(cfgHoldCnt);
          end else begin
            cnt <= cnt - ONE;
          end
        end
        default: begin
          if (aux != '0) aux <= aux - ONE;
          if (cnt <= ONE) state <= ST_IDLE;
          else cnt <= cnt - ONE;
        end
      endcase
    end
  end

  always_comb begin
    strobes       = '0;
    strobes.load  = accept;
    strobes.ceN   = 1'b1;
    strobes.semN  = 1'b1;
    strobes.rwN   = 1'b1;
    strobes.oeN   = 1'b1;
    case (state)
      ST_SETUP: begin
        strobes.oeN   = !oeLowR;
        strobes.ceN   = ceModeR || semR;
        strobes.semN  = ceModeR || !semR;
        strobes.rwN   = !ceModeR;
        strobes.drive = !lateDrive;
      end
      ST_PULSE: begin
        strobes.oeN   = !oeLowR;
        strobes.ceN   = semR;
        strobes.semN  = !semR;
        strobes.rwN   = 1'b0;
        strobes.drive = lateDrive ? (aux == '0) : 1'b1;
      end
      ST_RECOV: begin
        strobes.oeN   = !oeLowR;
        strobes.drive = (aux != '0);
        strobes.done  = (cnt <= ONE);
      end
      default: ;
    endcase
  end

  // R11: a taken request closes the handshake on the next cycle
  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R10: a completed recovery returns to idle
  a_r10_done_then_idle: assert property (@(posedge clk) disable iff (!rstN)
    strobes.done |=> reqReady);

endmodule

// File: rtl/sram_wr_dpath.sv
module sram_wr_dpath
  import sram_wr_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeSet_t    strobes,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memDout,
  output logic          memDoe,
  output logic          memCeN,
  output logic          memSemN,
  output logic          memRwN,
  output logic          memOeN,
  output logic          done
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      memDout <= '0;
      memDoe  <= 1'b0;
      memCeN  <= 1'b1;
      memSemN <= 1'b1;
      memRwN  <= 1'b1;
      memOeN  <= 1'b1;
      done    <= 1'b0;
    end else begin
      if (strobes.load) begin
        memAddr <= reqAddr;
        memDout <= reqData;
      end
      memDoe  <= strobes.drive;
      memCeN  <= strobes.ceN;
      memSemN <= strobes.semN;
      memRwN  <= strobes.rwN;
      memOeN  <= strobes.oeN;
      done    <= strobes.done;
    end
  end

  // R2: array and semaphore enables are exclusive
  a_r2_exclusive_enables: assert property (@(posedge clk) disable iff (!rstN)
    !(!memCeN && !memSemN));

  // R3: the address moves only while every write strobe is high
  a_r3_addr_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (memAddr != $past(memAddr)) |-> ($past(memCeN) && $past(memSemN) && $past(memRwN)));

  // R4, R5: read/write and the enable rise in the same cycle
  a_r4_rise_together: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRwN) |-> (memCeN && memSemN));

  // R8: driven data is stable
  a_r8_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memDoe && $past(memDoe)) |-> $stable(memDout));

  // R10: done lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 9,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  input  logic          reqSem,
  input  logic          cfgCeMode,
  input  logic          cfgOeLow,
  input  logic [CW-1:0] cfgSetupCnt,
  input  logic [CW-1:0] cfgPulseCnt,
  input  logic [CW-1:0] cfgAddrValidCnt,
  input  logic [CW-1:0] cfgDataSetupCnt,
  input  logic [CW-1:0] cfgTurnoffCnt,
  input  logic [CW-1:0] cfgHoldCnt,
  input  logic [CW-1:0] cfgRecovCnt,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memDout,
  output logic          memDoe,
  output logic          memCeN,
  output logic          memSemN,
  output logic          memRwN,
  output logic          memOeN,
  output logic          done
);

  strobeSet_t strobes;

  sram_wr_ctrl #(.CW(CW)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSem(reqSem),
    .cfgCeMode(cfgCeMode), .cfgOeLow(cfgOeLow),
    .cfgSetupCnt(cfgSetupCnt), .cfgPulseCnt(cfgPulseCnt),
    .cfgAddrValidCnt(cfgAddrValidCnt), .cfgDataSetupCnt(cfgDataSetupCnt),
    .cfgTurnoffCnt(cfgTurnoffCnt), .cfgHoldCnt(cfgHoldCnt),
    .cfgRecovCnt(cfgRecovCnt), .reqReady(reqReady), .strobes(strobes)
  );

  sram_wr_dpath #(.AW(AW), .DW(DW)) i_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .reqData(reqData), .memAddr(memAddr), .memDout(memDout),
    .memDoe(memDoe), .memCeN(memCeN), .memSemN(memSemN),
    .memRwN(memRwN), .memOeN(memOeN), .done(done)
  );

endmodule

// File: tb/test_sram_wr_seq.sv
module test_sram_wr_seq;
  localparam int AW = 14;
  localparam int DW = 9;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic reqSem = 1'b0;
  logic cfgCeMode = 1'b0;
  logic cfgOeLow = 1'b0;
  logic [CW-1:0] cfgSetupCnt = '0, cfgPulseCnt = '0, cfgAddrValidCnt = '0;
  logic [CW-1:0] cfgDataSetupCnt = '0, cfgTurnoffCnt = '0, cfgHoldCnt = '0, cfgRecovCnt = '0;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memDout;
  logic memDoe, memCeN, memSemN, memRwN, memOeN, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sram_wr_seq i_sram_wr_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqData(reqData), .reqSem(reqSem),
    .cfgCeMode(cfgCeMode), .cfgOeLow(cfgOeLow), .cfgSetupCnt(cfgSetupCnt),
    .cfgPulseCnt(cfgPulseCnt), .cfgAddrValidCnt(cfgAddrValidCnt),
    .cfgDataSetupCnt(cfgDataSetupCnt), .cfgTurnoffCnt(cfgTurnoffCnt),
    .cfgHoldCnt(cfgHoldCnt), .cfgRecovCnt(cfgRecovCnt), .memAddr(memAddr),
    .memDout(memDout), .memDoe(memDoe), .memCeN(memCeN), .memSemN(memSemN),
    .memRwN(memRwN), .memOeN(memOeN), .done(done)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic bit inside2(input int i, input int lo, input int hi);
    return (i >= lo) && (i <= hi);
  endfunction

  // one write; called and returns at a falling edge
  task automatic runWrite(input int ce, input int oe, input int sem, input int as,
                          input int wp, input int ds, input int toff, input int aw,
                          input int rc, input int hd, input int seed);
    int sLen, pLen, qLen, last, drvStart, drvEnd;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    a = AW'(seed * 37 + 5);
    d = DW'(seed * 11 + 3);
    sLen = imax(as, 1);
    pLen = imax(imax(wp, ds), 1);
    if (aw > as) pLen = imax(pLen, aw - as);
    if (ce == 0 && oe == 1) pLen = imax(pLen, toff + ds);
    qLen = imax(imax(rc, hd), 1);
    last = sLen + pLen + qLen;
    drvStart = (ce == 0 && oe == 1) ? sLen + 1 + toff : 1;
    drvEnd = sLen + pLen + hd;
    cfgCeMode = ce[0]; cfgOeLow = oe[0]; reqSem = sem[0];
    cfgSetupCnt = CW'(as); cfgPulseCnt = CW'(wp); cfgDataSetupCnt = CW'(ds);
    cfgTurnoffCnt = CW'(toff); cfgAddrValidCnt = CW'(aw);
    cfgRecovCnt = CW'(rc); cfgHoldCnt = CW'(hd);
    reqAddr = a; reqData = d; reqValid = 1'b1;
    chk("R11 ready before request", int'(reqReady), 1);
    for (int i = 0; i <= last + 1; i++) begin
      int enExp, rwExp;
      @(negedge clk);
      if (ce == 0) begin
        enExp = inside2(i, 1, sLen + pLen) ? 0 : 1;
        rwExp = inside2(i, sLen + 1, sLen + pLen) ? 0 : 1;
      end else begin
        enExp = inside2(i, sLen + 1, sLen + pLen) ? 0 : 1;
        rwExp = inside2(i, 1, sLen + pLen) ? 0 : 1;
      end
      chk(sem ? "R2 semaphore enable" : "R2 array enable",
          int'(sem ? memSemN : memCeN), enExp);
      chk("R2 other enable high", int'(sem ? memCeN : memSemN), 1);
      chk(ce ? "R5 read/write strobe" : "R4 read/write strobe", int'(memRwN), rwExp);
      chk("R6 pulse end via rw", int'(memRwN), rwExp);
      if (i >= 1)
        chk("R7 output enable", int'(memOeN), (oe == 1 && i <= last) ? 0 : 1);
      chk("R8 R9 data drive", int'(memDoe), inside2(i, drvStart, drvEnd) ? 1 : 0);
      if (memDoe) chk("R8 driven data", int'(memDout), int'(d));
      chk("R3 address held", int'(memAddr), int'(a));
      chk("R10 done pulse", int'(done), (i == last) ? 1 : 0);
      chk("R11 ready", int'(reqReady), (i >= last) ? 1 : 0);
      // stimulus: drop request, then present a rival one while busy
      if (i == 0) reqValid = 1'b0;
      if (i == 1) begin reqValid = 1'b1; reqAddr = ~a; reqData = ~d; end
      if (i == 2) begin reqValid = 1'b0; reqAddr = a; reqData = d; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int asV[3] = '{0, 1, 2};
    int wpV[3] = '{0, 1, 3};
    int hdV[3] = '{0, 1, 3};
    int seed = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ce high", int'(memCeN), 1);
    chk("R1 sem high", int'(memSemN), 1);
    chk("R1 rw high", int'(memRwN), 1);
    chk("R1 oe high", int'(memOeN), 1);
    chk("R1 drive off", int'(memDoe), 0);
    chk("R1 done low", int'(done), 0);
    chk("R1 ready", int'(reqReady), 1);
    for (int ce = 0; ce < 2; ce++)
      for (int oe = 0; oe < 2; oe++)
        for (int ia = 0; ia < 3; ia++)
          for (int iw = 0; iw < 3; iw++)
            for (int ds = 0; ds <= 2; ds += 2)
              for (int toff = 0; toff <= 2; toff += 2)
                for (int aw = 0; aw <= 4; aw += 4)
                  for (int rc = 0; rc <= 2; rc += 2)
                    for (int ih = 0; ih < 3; ih++) begin
                      runWrite(ce, oe, seed % 2, asV[ia], wpV[iw], ds, toff, aw,
                               rc, hdV[ih], seed);
                      seed++;
                    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule